// File: doc/BRIEF.md
# Codec Slot-Mapped Data FIFO

This block links a processor's register interface to a time-slotted audio codec link through a pair of 16-bit, 8-entry queues. The transmit queue is filled by processor pushes and drained when the codec link asks for a word on the slot the queue is bound to. The receive queue is filled from words the link delivers on its bound slot and drained by processor pops. The serial codec frame is not modelled. It appears here as a request strobe or a valid strobe, each carrying a 4-bit slot index.

Each queue has its own 12-bit control register. The fields are a 2-bit connection select, a DMA-routing bit, a stereo bit, a 4-bit slot number and a 4-bit level threshold. In stereo mode a queue serves its slot and the slot after it. Left and right samples therefore take turns in the queue, with left first. The block raises sticky error flags when the transmit side cannot serve a request or the receive side has no room for a word. When a queue reaches its programmed threshold it raises either an interrupt or a DMA request.

Top module: `codec_slot_fifo`

## Requirements
- R1: After reset both levels are 0, both error flags are 0, all interrupt and DMA outputs are 0, `slot_tx_data` is 0x0000, and both control registers are 0, so the connection is off.
- R2: The transmit queue holds up to DEPTH words and serves them in push order. A push while it is full is dropped.
- R3: The control layout is thr[11:8], slot[7:4], stereo[3], dma_sel[2], conn[1:0]. A queue is bound to the link only when conn = 2'b10. With mono mode and slot s, a request with index s puts the head word on `slot_tx_data` in the same cycle and removes that word at the clock edge. A request with any other index leaves the level unchanged, and `slot_tx_data` reads 0x0000.
- R4: When conn is not 2'b10, link requests and arrivals are ignored. Levels and error flags stay as they were.
- R5: With stereo = 1 and slot s, a queue serves index s and index s+1, in queue order, so the first word pushed goes to slot s. With s = 15, only index 15 is served, and index 0 is ignored.
- R6: A matching transmit request while the queue is empty drives 0x0000, leaves the level unchanged, and sets `tx_underflow` at that clock edge.
- R7: A matching arrival is stored. The processor reads arrivals in order: `rx_rdata` shows the head word, or 0x0000 when the queue is empty, and `rx_pop` removes the head.
- R8: A matching arrival while the receive queue is full is lost, the stored words are kept, and `rx_overflow` is set.
- R9: Both error flags are sticky. A `stat_clr_wr` cycle clears `tx_underflow` if bit 0 of `stat_clr_bits` is 1, and clears `rx_overflow` if bit 1 is 1. A 0 bit leaves its flag unchanged. A new error in the same cycle wins over the clear.
- R10: A nonzero thr arms the threshold. The transmit side fires when its free entries are at least thr, and the receive side fires when its stored words are at least thr. A thr of 0 never fires.
- R11: A firing threshold drives the interrupt output when dma_sel = 0 and the DMA request output when dma_sel = 1, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_tx_wr | input | 1 | Write `ctl_wdata` to the transmit control register |
| ctl_rx_wr | input | 1 | Write `ctl_wdata` to the receive control register |
| ctl_wdata | input | 12 | Control word |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe for the error flags |
| stat_clr_bits | input | 2 | Bit 0 clears underflow, bit 1 clears overflow |
| tx_push | input | 1 | Processor push into the transmit queue |
| tx_wdata | input | DATA_W | Word to push |
| tx_level | output | CNT_W | Transmit queue fill level |
| rx_pop | input | 1 | Processor pop from the receive queue |
| rx_rdata | output | DATA_W | Receive head word, 0 when empty |
| rx_level | output | CNT_W | Receive queue fill level |
| slot_req | input | 1 | Link asks for a transmit word |
| slot_req_idx | input | 4 | Slot index of the request |
| slot_tx_data | output | DATA_W | Word supplied to the link |
| slot_rx_vld | input | 1 | Link delivers a word |
| slot_rx_idx | input | 4 | Slot index of the delivered word |
| slot_rx_data | input | DATA_W | Delivered word |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| tx_irq | output | 1 | Transmit threshold interrupt |
| tx_dma_req | output | 1 | Transmit threshold DMA request |
| rx_irq | output | 1 | Receive threshold interrupt |
| rx_dma_req | output | 1 | Receive threshold DMA request |

## Verification
The bench builds the block with its defaults, DATA_W = 16 and DEPTH = 8. With a depth of 8, both queues can be filled past capacity within a few cycles. That brings the full-queue push drop, the lost ninth arrival and the empty-queue request into short directed scenarios. The 4-bit slot index makes the top slot reachable, so the stereo case that has no next slot is tested against the wrap to slot 0.

// File: rtl/codec_fifo_pkg.sv
package codec_fifo_pkg;

  localparam int unsigned CF_SLOT_W = 4;
  localparam int unsigned CF_THR_W  = 4;
  localparam int unsigned CF_CTL_W  = 12;
  localparam logic [1:0]  CF_CONN_CODEC = 2'b10;

  // Control register layout, MSB first
  typedef struct packed {
    logic [CF_THR_W-1:0]  thr;
    logic [CF_SLOT_W-1:0] slot;
    logic                 stereo;
    logic                 dma_sel;
    logic [1:0]           conn;
  } cf_ctl_t;

  // True when a strobe with index idx belongs to the queue set up by c
  function automatic logic slot_selected(cf_ctl_t c, logic [CF_SLOT_W-1:0] idx);
    logic [CF_SLOT_W:0] nxt;
    nxt = {1'b0, c.slot} + (CF_SLOT_W+1)'(1);
    return (c.conn == CF_CONN_CODEC) &&
           ((idx == c.slot) ||
            (c.stereo && !nxt[CF_SLOT_W] && (idx == nxt[CF_SLOT_W-1:0])));
  endfunction

  // Threshold test: zero threshold disarms
  function automatic logic level_reached(int unsigned amount, int unsigned thr);
    return (thr != 0) && (amount >= thr);
  endfunction

endpackage

// File: rtl/codec_fifo_store.sv
module codec_fifo_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              push_done,
  output logic              pop_done
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (level == CNT_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_done = push_req && !full;
  assign pop_done  = pop_req && !empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_done) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_done) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_done)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_done, pop_done})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/codec_slot_gate.sv
module codec_slot_gate
  import codec_fifo_pkg::*;
(
  input  cf_ctl_t              ctl,
  input  logic                 strobe,
  input  logic [CF_SLOT_W-1:0] idx,
  output logic                 hit
);
  assign hit = strobe && slot_selected(ctl, idx);
endmodule

// File: rtl/codec_fifo_events.sv
module codec_fifo_events
  import codec_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  cf_ctl_t          ctl,
  input  logic [CNT_W-1:0] amount,
  output logic             irq,
  output logic             dma_req
);
  logic met;
  assign met     = level_reached(32'(amount), 32'(ctl.thr));
  assign irq     = met && !ctl.dma_sel;
  assign dma_req = met &&  ctl.dma_sel;
endmodule

// File: rtl/codec_slot_fifo.sv
module codec_slot_fifo
  import codec_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_tx_wr,
  input  logic                 ctl_rx_wr,
  input  logic [CF_CTL_W-1:0]  ctl_wdata,
  input  logic                 stat_clr_wr,
  input  logic [1:0]           stat_clr_bits,
  input  logic                 tx_push,
  input  logic [DATA_W-1:0]    tx_wdata,
  output logic [CNT_W-1:0]     tx_level,
  input  logic                 rx_pop,
  output logic [DATA_W-1:0]    rx_rdata,
  output logic [CNT_W-1:0]     rx_level,
  input  logic                 slot_req,
  input  logic [CF_SLOT_W-1:0] slot_req_idx,
  output logic [DATA_W-1:0]    slot_tx_data,
  input  logic                 slot_rx_vld,
  input  logic [CF_SLOT_W-1:0] slot_rx_idx,
  input  logic [DATA_W-1:0]    slot_rx_data,
  output logic                 tx_underflow,
  output logic                 rx_overflow,
  output logic                 tx_irq,
  output logic                 tx_dma_req,
  output logic                 rx_irq,
  output logic                 rx_dma_req
);

  cf_ctl_t tx_ctl, rx_ctl;

  // Named internal events, visible to the bound checker
  logic tx_hit, rx_hit;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_push_done, tx_pop_done, rx_push_done, rx_pop_done;
  logic underflow_evt, overflow_evt;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0]  tx_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ctl <= '0;
      rx_ctl <= '0;
    end else begin
      if (ctl_tx_wr) tx_ctl <= cf_ctl_t'(ctl_wdata);
      if (ctl_rx_wr) rx_ctl <= cf_ctl_t'(ctl_wdata);
    end
  end

  codec_slot_gate tx_gate_i (
    .ctl(tx_ctl), .strobe(slot_req), .idx(slot_req_idx), .hit(tx_hit)
  );
  codec_slot_gate rx_gate_i (
    .ctl(rx_ctl), .strobe(slot_rx_vld), .idx(slot_rx_idx), .hit(rx_hit)
  );

  codec_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_store_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(tx_push), .push_data(tx_wdata), .pop_req(tx_hit),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_done(tx_push_done), .pop_done(tx_pop_done)
  );

  codec_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_store_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_hit), .push_data(slot_rx_data), .pop_req(rx_pop),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_done(rx_push_done), .pop_done(rx_pop_done)
  );

  assign underflow_evt = tx_hit && tx_empty;
  assign overflow_evt  = rx_hit && rx_full;
  assign slot_tx_data  = tx_pop_done ? tx_head : '0;
  assign rx_rdata      = rx_empty ? '0 : rx_head;
  assign tx_free       = CNT_W'(DEPTH) - tx_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_underflow <= 1'b0;
      rx_overflow  <= 1'b0;
    end else begin
      tx_underflow <= underflow_evt ||
                      (tx_underflow && !(stat_clr_wr && stat_clr_bits[0]));
      rx_overflow  <= overflow_evt ||
                      (rx_overflow && !(stat_clr_wr && stat_clr_bits[1]));
    end
  end

  codec_fifo_events #(.CNT_W(CNT_W)) tx_evt_i (
    .ctl(tx_ctl), .amount(tx_free), .irq(tx_irq), .dma_req(tx_dma_req)
  );
  codec_fifo_events #(.CNT_W(CNT_W)) rx_evt_i (
    .ctl(rx_ctl), .amount(rx_level), .irq(rx_irq), .dma_req(rx_dma_req)
  );

endmodule

// File: rtl/codec_slot_fifo_chk.sv
module codec_slot_fifo_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_hit,
  input logic              tx_empty,
  input logic              tx_push,
  input logic [CNT_W-1:0]  tx_level,
  input logic [DATA_W-1:0] slot_tx_data,
  input logic              tx_underflow,
  input logic              rx_hit,
  input logic              rx_full,
  input logic              rx_pop,
  input logic [CNT_W-1:0]  rx_level,
  input logic              rx_overflow,
  input logic              stat_clr_wr,
  input logic [1:0]        stat_clr_bits,
  input logic              tx_irq,
  input logic              tx_dma_req,
  input logic              rx_irq,
  input logic              rx_dma_req
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

  assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && tx_empty) |-> (slot_tx_data == '0));

  assert_underflow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && tx_empty && !tx_push) |=> $stable(tx_level));

  assert_underflow_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && tx_empty) |=> tx_underflow);

  assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && rx_full) |=> rx_overflow);

  assert_overflow_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && rx_full && !rx_pop) |=> (rx_level == CNT_W'(DEPTH)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underflow && !(stat_clr_wr && stat_clr_bits[0])) |=> tx_underflow);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_wr && stat_clr_bits[1] && !(rx_hit && rx_full)) |=> !rx_overflow);

  assert_route_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_irq && tx_dma_req) && !(rx_irq && rx_dma_req));

endmodule

bind codec_slot_fifo codec_slot_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tx_hit(tx_hit), .tx_empty(tx_empty), .tx_push(tx_push),
  .tx_level(tx_level), .slot_tx_data(slot_tx_data), .tx_underflow(tx_underflow),
  .rx_hit(rx_hit), .rx_full(rx_full), .rx_pop(rx_pop),
  .rx_level(rx_level), .rx_overflow(rx_overflow),
  .stat_clr_wr(stat_clr_wr), .stat_clr_bits(stat_clr_bits),
  .tx_irq(tx_irq), .tx_dma_req(tx_dma_req),
  .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
);

// File: tb/codec_slot_fifo_tb_top.sv
`timescale 1ns/1ps
module codec_slot_fifo_tb_top;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctl_tx_wr, ctl_rx_wr;
  logic [11:0]       ctl_wdata;
  logic              stat_clr_wr;
  logic [1:0]        stat_clr_bits;
  logic              tx_push;
  logic [DATA_W-1:0] tx_wdata;
  logic [CNT_W-1:0]  tx_level;
  logic              rx_pop;
  logic [DATA_W-1:0] rx_rdata;
  logic [CNT_W-1:0]  rx_level;
  logic              slot_req;
  logic [3:0]        slot_req_idx;
  logic [DATA_W-1:0] slot_tx_data;
  logic              slot_rx_vld;
  logic [3:0]        slot_rx_idx;
  logic [DATA_W-1:0] slot_rx_data;
  logic              tx_underflow, rx_overflow;
  logic              tx_irq, tx_dma_req, rx_irq, rx_dma_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  codec_slot_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_tx_wr(ctl_tx_wr), .ctl_rx_wr(ctl_rx_wr), .ctl_wdata(ctl_wdata),
    .stat_clr_wr(stat_clr_wr), .stat_clr_bits(stat_clr_bits),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level),
    .slot_req(slot_req), .slot_req_idx(slot_req_idx), .slot_tx_data(slot_tx_data),
    .slot_rx_vld(slot_rx_vld), .slot_rx_idx(slot_rx_idx), .slot_rx_data(slot_rx_data),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
    .tx_irq(tx_irq), .tx_dma_req(tx_dma_req), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
  );

  // Control word per R3: thr[11:8] slot[7:4] stereo[3] dma_sel[2] conn[1:0]
  function automatic logic [11:0] mk_ctl(int thr, int slot, bit stereo, bit dma, logic [1:0] conn);
    return {4'(thr), 4'(slot), stereo, dma, conn};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(bit to_rx, logic [11:0] v);
    ctl_wdata = v;
    if (to_rx) ctl_rx_wr = 1'b1; else ctl_tx_wr = 1'b1;
    step();
    ctl_rx_wr = 1'b0;
    ctl_tx_wr = 1'b0;
  endtask

  task automatic push(logic [DATA_W-1:0] w);
    tx_push = 1'b1;
    tx_wdata = w;
    step();
    tx_push = 1'b0;
  endtask

  task automatic tx_slot(int idx, logic [DATA_W-1:0] exp, string tag);
    slot_req = 1'b1;
    slot_req_idx = 4'(idx);
    #1;
    check(tag, 32'(slot_tx_data), 32'(exp));
    @(negedge clk);
    slot_req = 1'b0;
  endtask

  task automatic rx_in(int idx, logic [DATA_W-1:0] w);
    slot_rx_vld = 1'b1;
    slot_rx_idx = 4'(idx);
    slot_rx_data = w;
    step();
    slot_rx_vld = 1'b0;
  endtask

  task automatic rx_read(logic [DATA_W-1:0] exp, string tag);
    check(tag, 32'(rx_rdata), 32'(exp));
    rx_pop = 1'b1;
    step();
    rx_pop = 1'b0;
  endtask

  task automatic clr(logic [1:0] bits);
    stat_clr_wr = 1'b1;
    stat_clr_bits = bits;
    step();
    stat_clr_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 tx_level", 32'(tx_level), 0);
    check("R1 rx_level", 32'(rx_level), 0);
    check("R1 flags", {30'd0, tx_underflow, rx_overflow}, 0);
    check("R1 events", {28'd0, tx_irq, tx_dma_req, rx_irq, rx_dma_req}, 0);
    check("R1 slot_tx_data", 32'(slot_tx_data), 0);
    tx_slot(0, 16'h0000, "R1 disabled request");
    check("R1 no underflow when off", 32'(tx_underflow), 0);
  endtask

  task automatic t_tx_mono();
    wr_ctl(0, mk_ctl(0, 5, 0, 0, 2'b10));
    push(16'hAAAA); push(16'hBBBB); push(16'hCCCC);
    check("R2 level after 3 pushes", 32'(tx_level), 3);
    tx_slot(4, 16'h0000, "R3 other slot data");
    check("R3 other slot level", 32'(tx_level), 3);
    tx_slot(5, 16'hAAAA, "R3 head word");
    check("R3 level after serve", 32'(tx_level), 2);
    wr_ctl(0, mk_ctl(0, 5, 0, 0, 2'b01));
    tx_slot(5, 16'h0000, "R4 conn off data");
    check("R4 conn off level", 32'(tx_level), 2);
    check("R4 conn off no underflow", 32'(tx_underflow), 0);
    wr_ctl(0, mk_ctl(0, 5, 0, 0, 2'b10));
    tx_slot(5, 16'hBBBB, "R3 second word");
    tx_slot(5, 16'hCCCC, "R3 third word");
    check("R3 drained", 32'(tx_level), 0);
  endtask

  task automatic t_depth();
    for (int i = 0; i < DEPTH + 1; i++) push(16'(16'h0100 + i));
    check("R2 full level", 32'(tx_level), DEPTH);
    for (int i = 0; i < DEPTH; i++) tx_slot(5, 16'(16'h0100 + i), "R2 order");
    check("R2 extra push dropped", 32'(tx_level), 0);
  endtask

  task automatic t_underflow();
    tx_slot(5, 16'h0000, "R6 zero on empty");
    check("R6 level unchanged", 32'(tx_level), 0);
    check("R6 underflow set", 32'(tx_underflow), 1);
    step();
    check("R9 sticky", 32'(tx_underflow), 1);
    clr(2'b10);
    check("R9 other bit keeps underflow", 32'(tx_underflow), 1);
    clr(2'b01);
    check("R9 cleared", 32'(tx_underflow), 0);
  endtask

  task automatic t_stereo();
    wr_ctl(0, mk_ctl(0, 6, 1, 0, 2'b10));
    push(16'h1111); push(16'h2222);
    tx_slot(6, 16'h1111, "R5 left on slot");
    tx_slot(7, 16'h2222, "R5 right on next slot");
    tx_slot(8, 16'h0000, "R5 slot beyond pair");
    check("R5 no underflow beyond pair", 32'(tx_underflow), 0);
    wr_ctl(0, mk_ctl(0, 15, 1, 0, 2'b10));
    push(16'h3333);
    tx_slot(0, 16'h0000, "R5 no wrap from 15");
    check("R5 wrap level", 32'(tx_level), 1);
    tx_slot(15, 16'h3333, "R5 slot 15 served");
  endtask

  task automatic t_rx();
    wr_ctl(1, mk_ctl(0, 3, 0, 0, 2'b10));
    check("R7 empty reads zero", 32'(rx_rdata), 0);
    rx_in(3, 16'h00A0);
    rx_in(2, 16'h00BB);
    check("R7 other slot ignored", 32'(rx_level), 1);
    rx_in(3, 16'h00A1);
    rx_read(16'h00A0, "R7 first word");
    rx_read(16'h00A1, "R7 second word");
    wr_ctl(1, mk_ctl(0, 3, 0, 0, 2'b00));
    rx_in(3, 16'h00DD);
    check("R4 rx conn off", 32'(rx_level), 0);
    wr_ctl(1, mk_ctl(0, 9, 1, 0, 2'b10));
    rx_in(9, 16'h0123); rx_in(10, 16'h0456); rx_in(11, 16'h0789);
    check("R5 rx stereo level", 32'(rx_level), 2);
    rx_read(16'h0123, "R5 rx left");
    rx_read(16'h0456, "R5 rx right");
  endtask

  task automatic t_overflow();
    wr_ctl(1, mk_ctl(0, 3, 0, 0, 2'b10));
    for (int i = 0; i < DEPTH + 1; i++) rx_in(3, 16'(16'h00C0 + i));
    check("R8 level full", 32'(rx_level), DEPTH);
    check("R8 overflow set", 32'(rx_overflow), 1);
    for (int i = 0; i < DEPTH; i++) rx_read(16'(16'h00C0 + i), "R8 contents kept");
    check("R8 lost word absent", 32'(rx_level), 0);
    clr(2'b01);
    check("R9 overflow kept", 32'(rx_overflow), 1);
    clr(2'b10);
    check("R9 overflow cleared", 32'(rx_overflow), 0);
  endtask

  task automatic t_thresh();
    wr_ctl(0, mk_ctl(6, 5, 0, 0, 2'b10));
    check("R10 tx free 8 >= 6", 32'(tx_irq), 1);
    push(16'h0001); push(16'h0002); push(16'h0003);
    check("R10 tx free 5 < 6", {30'd0, tx_irq, tx_dma_req}, 0);
    wr_ctl(0, mk_ctl(6, 5, 0, 1, 2'b10));
    tx_slot(5, 16'h0001, "R10 drain one");
    check("R11 tx routed to dma", {30'd0, tx_irq, tx_dma_req}, 1);
    wr_ctl(1, mk_ctl(4, 3, 0, 0, 2'b10));
    rx_in(3, 16'h0011); rx_in(3, 16'h0012); rx_in(3, 16'h0013);
    check("R10 rx 3 < 4", 32'(rx_irq), 0);
    rx_in(3, 16'h0014);
    check("R11 rx irq routing", {30'd0, rx_irq, rx_dma_req}, 2);
    wr_ctl(1, mk_ctl(4, 3, 0, 1, 2'b10));
    check("R11 rx dma routing", {30'd0, rx_irq, rx_dma_req}, 1);
    wr_ctl(1, mk_ctl(0, 3, 0, 1, 2'b10));
    check("R10 zero threshold off", {30'd0, rx_irq, rx_dma_req}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_tx_wr = 0; ctl_rx_wr = 0; ctl_wdata = '0;
    stat_clr_wr = 0; stat_clr_bits = '0;
    tx_push = 0; tx_wdata = '0; rx_pop = 0;
    slot_req = 0; slot_req_idx = '0;
    slot_rx_vld = 0; slot_rx_idx = '0; slot_rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx_mono();
    t_depth();
    t_underflow();
    t_stereo();
    t_rx();
    t_overflow();
    t_thresh();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule